// File: doc/BRIEF.md
# Low-Power Real-Time Counter with Seconds Alarm

This block is a battery-domain real-time counter. A free-running binary counter advances on every edge of a slow timekeeping clock, nominally 32.768 kHz. Its upper 32 bits hold elapsed whole seconds. The lower `FRAC_W` bits count sub-second ticks. A bus-clock register interface gives software access to control bits, the counter words, a seconds alarm, a sticky alarm-hit status flag and a free storage word used for glitch-detector initialisation.

Control bits are written in the bus clock domain. Each bit reaches the slow domain through a synchroniser and comes back through a second synchroniser. A control read therefore shows the state the counter logic is actually using, not the value last written. Software changes the counter by first clearing the count enable and waiting until the readback shows it cleared. It then writes the counter words and enables counting again.

An alarm match sets the status flag. The interrupt output follows that flag, gated by the applied alarm enable. The wakeup output also needs the applied wakeup enable.

Top module: `rtc_lp_top`

## Requirements
- R1: After reset, the control readback, the status word, both counter words, `irq` and `wakeup` are all zero.
- R2: The control word is at offset 0x04. Bit 0 is count enable, bit 1 is alarm enable and bit 3 is wakeup enable. A read returns the applied state after the round trip to the slow domain, so a read issued in the cycle after a write still returns the old value.
- R3: While count enable is applied, the counter increments by one on every slow-clock edge. Offset 0x20 returns counter bits 31:0. Offset 0x1C returns the bits above 31, zero-extended, and a carry out of the low word reaches it.
- R4: The seconds value is the counter shifted right by `FRAC_W`. The 32-bit alarm at offset 0x24 is compared against that value and reads back as written.
- R5: A write to either counter word is ignored while count enable is requested or applied.
- R6: While counting is disabled, counter-word writes load the counter and the counter holds its value. Counting then resumes from the loaded value once it is enabled again.
- R7: Status bit 0 at offset 0x18 sets when the seconds value equals the alarm while alarm enable is applied. It does not set while alarm enable is clear.
- R8: The status flag is sticky. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged.
- R9: `irq` is high exactly when the status flag is set and alarm enable is applied.
- R10: `wakeup` is high only when `irq` is high and wakeup enable is applied.
- R11: Offset 0x30 stores any 32-bit value, including 0x41736166, and reads it back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register interface clock |
| slow_clk | input | 1 | Timekeeping clock that advances the counter |
| rst_n | input | 1 | Active-low reset, synchronous in each domain |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Alarm interrupt |
| wakeup | output | 1 | Alarm wakeup request |

## Verification
Embedded properties check on every cycle that:
- the counter steps by exactly one while enabled and holds when disabled and not being loaded;
- the status flag keeps its value unless it is cleared, clears on a write of 1, and rises only after a synchronised match;
- the counter-load toggles move only while counting is off.

Directed scenarios are needed for the behaviour that spans the crossings:
- the lagging control readback;
- a load that survives re-enable;
- a carry into the high word;
- alarm timing in seconds;
- the gating of `irq` and `wakeup` by the applied enables.

// File: rtl/rtc_lp_pkg.sv
// Shared register offsets, control bit positions and the control bundle type.
package rtc_lp_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_ALARM  = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_GLITCH = 6'h30;

    localparam int BIT_CNT_EN  = 0;
    localparam int BIT_ALM_EN  = 1;
    localparam int BIT_WAKE_EN = 3;
    localparam int BIT_HIT     = 0;

    typedef struct packed {
        logic wake_en;
        logic alm_en;
        logic cnt_en;
    } ctrl_t;
endpackage

// File: rtl/rtc_sync.sv
// Multi-flop synchroniser.
// Assumes each bit is independent or quasi-static for the
// duration of the crossing. Resets to zero.
module rtc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rtc_slow_core.sv
// Slow-domain timekeeping core: counter, counter-load pickup and alarm compare.
// Assumes the control bundle is already synchronised to slow_clk.
// Assumes the load values are stable once their toggle has flipped.
// Assumes the alarm value is not changed while the alarm is enabled.
module rtc_slow_core
    import rtc_lp_pkg::*;
#(
    parameter int CNT_W  = 47,
    parameter int FRAC_W = 15
) (
    input  logic                slow_clk,
    input  logic                rst_n,
    input  ctrl_t               ctrl_s,
    input  logic                ld_lo_tog,
    input  logic                ld_hi_tog,
    input  logic [31:0]         ld_lo_val,
    input  logic [CNT_W-33:0]   ld_hi_val,
    input  logic [CNT_W-FRAC_W-1:0] alarm,
    output logic [CNT_W-1:0]    cnt,
    output logic                hit
);
    localparam int SEC_W = CNT_W - FRAC_W;

    logic [1:0] tog_s;
    logic [1:0] tog_prev;
    logic       ld_lo;
    logic       ld_hi;

    rtc_sync #(.W(2), .STAGES(2)) u_tog_sync (
        .clk   (slow_clk),
        .rst_n (rst_n),
        .d     ({ld_hi_tog, ld_lo_tog}),
        .q     (tog_s)
    );

    // Remember the last toggle state to detect a new load request.
    always_ff @(posedge slow_clk) begin
        if (!rst_n) tog_prev <= '0;
        else        tog_prev <= tog_s;
    end

    assign ld_lo = (tog_s[0] ^ tog_prev[0]) && !ctrl_s.cnt_en;
    assign ld_hi = (tog_s[1] ^ tog_prev[1]) && !ctrl_s.cnt_en;

    // Advance the counter, or load its words while it is stopped.
    always_ff @(posedge slow_clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ctrl_s.cnt_en) begin
            cnt <= cnt + 1'b1;
        end else begin
            if (ld_lo) cnt[31:0]      <= ld_lo_val;
            if (ld_hi) cnt[CNT_W-1:32] <= ld_hi_val;
        end
    end

    // Register the seconds match, qualified by the applied alarm enable.
    always_ff @(posedge slow_clk) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= ctrl_s.alm_en && (cnt[CNT_W-1:FRAC_W] == alarm[SEC_W-1:0]);
    end

    // R3
    // cnt_step_chk
    cnt_step_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
        $past(ctrl_s.cnt_en) |-> (cnt == $past(cnt) + 1'b1));

    // R6
    // cnt_hold_chk
    cnt_hold_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (!$past(ctrl_s.cnt_en) && !$past(ld_lo) && !$past(ld_hi)) |-> $stable(cnt));
endmodule

// File: rtl/rtc_bus_regs.sv
// Bus-domain register file.
// Holds the requested control bits, the alarm, the glitch word, the sticky
// status flag and the counter-load staging.
// Assumes one access per strobe. Read data is registered.
// Counter and match inputs arrive already synchronised.
module rtc_bus_regs
    import rtc_lp_pkg::*;
#(
    parameter int CNT_W  = 47,
    parameter int FRAC_W = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  ctrl_t                   ctrl_rb,
    input  logic [CNT_W-1:0]        cnt_b,
    input  logic                    hit_b,
    output ctrl_t                   ctrl_req,
    output logic                    ld_lo_tog,
    output logic                    ld_hi_tog,
    output logic [31:0]             ld_lo_val,
    output logic [CNT_W-33:0]       ld_hi_val,
    output logic [CNT_W-FRAC_W-1:0] alarm,
    output logic                    irq,
    output logic                    wakeup
);
    localparam int HI_W  = CNT_W - 32;
    localparam int SEC_W = CNT_W - FRAC_W;

    logic        wr_en;
    logic        rd_en;
    logic        cnt_wr_ok;
    logic        hit_prev;
    logic        hit_set;
    logic        hit_clr;
    logic        flag;
    logic [31:0] glitch;

    assign wr_en     = bus_sel && bus_wr;
    assign rd_en     = bus_sel && !bus_wr;
    assign cnt_wr_ok = !ctrl_req.cnt_en && !ctrl_rb.cnt_en;
    assign hit_set   = hit_b && !hit_prev;
    assign hit_clr   = wr_en && (bus_addr == OFS_STAT) && bus_wdata[BIT_HIT];

    // Capture control, alarm and glitch-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_req <= '0;
            alarm    <= '0;
            glitch   <= '0;
        end else if (wr_en) begin
            if (bus_addr == OFS_CTRL) begin
                ctrl_req.cnt_en  <= bus_wdata[BIT_CNT_EN];
                ctrl_req.alm_en  <= bus_wdata[BIT_ALM_EN];
                ctrl_req.wake_en <= bus_wdata[BIT_WAKE_EN];
            end
            if (bus_addr == OFS_ALARM)  alarm  <= bus_wdata[SEC_W-1:0];
            if (bus_addr == OFS_GLITCH) glitch <= bus_wdata;
        end
    end

    // Stage counter-word loads and flip a toggle per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_lo_tog <= 1'b0;
            ld_hi_tog <= 1'b0;
            ld_lo_val <= '0;
            ld_hi_val <= '0;
        end else if (wr_en && cnt_wr_ok) begin
            if (bus_addr == OFS_CNT_LO) begin
                ld_lo_val <= bus_wdata;
                ld_lo_tog <= !ld_lo_tog;
            end
            if (bus_addr == OFS_CNT_HI) begin
                ld_hi_val <= bus_wdata[HI_W-1:0];
                ld_hi_tog <= !ld_hi_tog;
            end
        end
    end

    // Sticky alarm flag: a new match sets it, a written 1 clears it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_prev <= 1'b0;
            flag     <= 1'b0;
        end else begin
            hit_prev <= hit_b;
            flag     <= hit_set || (flag && !hit_clr);
        end
    end

    // Registered read multiplexer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_en) begin
            unique case (bus_addr)
                OFS_CTRL:   bus_rdata <= {28'd0, ctrl_rb.wake_en, 1'b0, ctrl_rb.alm_en, ctrl_rb.cnt_en};
                OFS_STAT:   bus_rdata <= {31'd0, flag};
                OFS_CNT_HI: bus_rdata <= {{(32-HI_W){1'b0}}, cnt_b[CNT_W-1:32]};
                OFS_CNT_LO: bus_rdata <= cnt_b[31:0];
                OFS_ALARM:  bus_rdata <= 32'(alarm);
                OFS_GLITCH: bus_rdata <= glitch;
                default:    bus_rdata <= '0;
            endcase
        end
    end

    assign irq    = flag && ctrl_rb.alm_en;
    assign wakeup = irq && ctrl_rb.wake_en;

    // R8
    // flag_w1c_chk
    flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hit_clr) && !$past(hit_b && !hit_prev)) |-> !flag);

    // R8
    // flag_keep_chk
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag) && !$past(hit_clr)) |-> flag);

    // R7
    // flag_rise_chk
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(hit_b));

    // R5
    // ld_guard_chk
    ld_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(ld_lo_tog) && $stable(ld_hi_tog)) |->
            (!$past(ctrl_req.cnt_en) && !$past(ctrl_rb.cnt_en)));
endmodule

// File: rtl/rtc_lp_top.sv
// Low-power real-time counter top.
// Wires the bus register file to the slow-domain core through synchronisers:
//   - control bits cross to the slow clock and return for readback;
//   - the counter value and the alarm match cross back to the bus clock.
// Assumes rst_n is held low long enough to span several slow-clock edges.
module rtc_lp_top
    import rtc_lp_pkg::*;
#(
    parameter int CNT_W       = 47,
    parameter int FRAC_W      = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic        bus_clk,
    input  logic        slow_clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        wakeup
);
    localparam int HI_W  = CNT_W - 32;
    localparam int SEC_W = CNT_W - FRAC_W;
    localparam int CTL_W = $bits(ctrl_t);

    ctrl_t             ctrl_req;
    ctrl_t             ctrl_s;
    ctrl_t             ctrl_rb;
    logic              ld_lo_tog;
    logic              ld_hi_tog;
    logic [31:0]       ld_lo_val;
    logic [HI_W-1:0]   ld_hi_val;
    logic [SEC_W-1:0]  alarm;
    logic [CNT_W-1:0]  cnt_s;
    logic [CNT_W-1:0]  cnt_b;
    logic              hit_s;
    logic              hit_b;

    rtc_bus_regs #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_regs (
        .clk       (bus_clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl_rb   (ctrl_rb),
        .cnt_b     (cnt_b),
        .hit_b     (hit_b),
        .ctrl_req  (ctrl_req),
        .ld_lo_tog (ld_lo_tog),
        .ld_hi_tog (ld_hi_tog),
        .ld_lo_val (ld_lo_val),
        .ld_hi_val (ld_hi_val),
        .alarm     (alarm),
        .irq       (irq),
        .wakeup    (wakeup)
    );

    rtc_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_ctrl_fwd (
        .clk (slow_clk), .rst_n (rst_n), .d (ctrl_req), .q (ctrl_s)
    );

    rtc_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_ctrl_ret (
        .clk (bus_clk), .rst_n (rst_n), .d (ctrl_s), .q (ctrl_rb)
    );

    rtc_slow_core #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_core (
        .slow_clk  (slow_clk),
        .rst_n     (rst_n),
        .ctrl_s    (ctrl_s),
        .ld_lo_tog (ld_lo_tog),
        .ld_hi_tog (ld_hi_tog),
        .ld_lo_val (ld_lo_val),
        .ld_hi_val (ld_hi_val),
        .alarm     (alarm),
        .cnt       (cnt_s),
        .hit       (hit_s)
    );

    rtc_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cnt_ret (
        .clk (bus_clk), .rst_n (rst_n), .d (cnt_s), .q (cnt_b)
    );

    rtc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_hit_ret (
        .clk (bus_clk), .rst_n (rst_n), .d (hit_s), .q (hit_b)
    );
endmodule

// File: tb/tb_rtc_lp_top.sv
module tb_rtc_lp_top;
    localparam int CNT_W  = 35;
    localparam int FRAC_W = 3;
    localparam logic [5:0] A_CTRL = 6'h04, A_STAT = 6'h18, A_HI = 6'h1C,
                           A_LO = 6'h20, A_ALM = 6'h24, A_GLT = 6'h30;

    logic bus_clk = 1'b0;
    logic slow_clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0;
    logic bus_wr = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq, wakeup;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 bus_clk = ~bus_clk;
    always #80  slow_clk = ~slow_clk;

    rtc_lp_top #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) dut (
        .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wakeup(wakeup)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge bus_clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge bus_clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_ctrl(input logic [31:0] v, input string tag);
        logic [31:0] r;
        bit seen = 1'b0;
        wr(A_CTRL, v);
        for (int i = 0; i < 400 && !seen; i++) begin
            rd(A_CTRL, r);
            if (r == v) seen = 1'b1;
        end
        check(seen, tag, r, v);
    endtask

    task automatic load_raw(input logic [31:0] hi, input logic [31:0] lo, input string tag);
        logic [31:0] rh, rl;
        bit seen = 1'b0;
        wr(A_LO, lo);
        wr(A_HI, hi);
        for (int i = 0; i < 400 && !seen; i++) begin
            rd(A_LO, rl); rd(A_HI, rh);
            if (rl == lo && rh == hi) seen = 1'b1;
        end
        check(seen, tag, rl, lo);
    endtask

    task automatic wait_irq(input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            @(negedge bus_clk);
            if (irq) seen = 1'b1;
        end
        check(seen, tag, {31'd0, irq}, 32'd1);
    endtask

    // R1: every readable state is zero after reset
    task automatic t_reset();
        logic [31:0] r;
        rd(A_CTRL, r); check(r == 0, "R1 ctrl", r, 0);
        rd(A_STAT, r); check(r == 0, "R1 status", r, 0);
        rd(A_LO, r);   check(r == 0, "R1 cnt lo", r, 0);
        rd(A_HI, r);   check(r == 0, "R1 cnt hi", r, 0);
        check(!irq && !wakeup, "R1 irq/wakeup", {30'd0, wakeup, irq}, 0);
    endtask

    // R2, R3, R5: enable lag, counting, ignored writes while counting
    task automatic t_enable();
        logic [31:0] r, a, b;
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, r); check(r == 0, "R2 readback lags write", r, 0);
        set_ctrl(32'h1, "R2 enable applied");
        rd(A_LO, a);
        repeat (200) @(negedge bus_clk);
        rd(A_LO, b); check(b > a, "R3 counter advances", b, a + 1);
        wr(A_LO, 32'hABCD_0000);
        wr(A_HI, 32'h7);
        repeat (200) @(negedge bus_clk);
        rd(A_LO, r); check(r < 32'h1_0000, "R5 lo write ignored", r, 32'h0);
        rd(A_HI, r); check(r == 0, "R5 hi write ignored", r, 0);
    endtask

    // R6, R3: load while stopped, hold, resume; carry into the high word
    task automatic t_load();
        logic [31:0] r, h;
        set_ctrl(32'h0, "R2 disable applied");
        load_raw(32'h0, 32'h10, "R6 load visible");
        repeat (300) @(negedge bus_clk);
        rd(A_LO, r); check(r == 32'h10, "R6 holds while stopped", r, 32'h10);
        set_ctrl(32'h1, "R2 re-enable applied");
        rd(A_LO, r);
        check(r >= 32'h10 && r < 32'h20, "R6 resumes from load", r, 32'h10);
        set_ctrl(32'h0, "R2 disable applied");
        load_raw(32'h0, 32'hFFFF_FFF0, "R6 load near wrap");
        set_ctrl(32'h1, "R2 enable applied");
        repeat (1200) @(negedge bus_clk);
        rd(A_HI, h); rd(A_LO, r);
        check(h == 1 && r < 32'h40, "R3 carry into hi word", h, 1);
    endtask

    // R4, R7, R8, R10: alarm fires at the right second, W1C semantics
    task automatic t_alarm();
        logic [31:0] r;
        set_ctrl(32'h0, "R2 disable applied");
        wr(A_STAT, 32'h1);
        load_raw(32'h0, 32'd5 << FRAC_W, "R6 load 5 s");
        wr(A_ALM, 32'd7);
        rd(A_ALM, r); check(r == 7, "R4 alarm readback", r, 7);
        set_ctrl(32'hB, "R2 all enables applied");
        rd(A_STAT, r); check(r == 0, "R7 no flag before match", r, 0);
        wait_irq("R7 alarm raises irq");
        rd(A_STAT, r); check(r == 1, "R7 flag set", r, 1);
        rd(A_LO, r); check((r >> FRAC_W) == 7, "R4 fires at alarm second", r >> FRAC_W, 7);
        check(wakeup, "R10 wakeup with enable", {31'd0, wakeup}, 1);
        wr(A_STAT, 32'h0);
        rd(A_STAT, r); check(r == 1, "R8 write 0 keeps flag", r, 1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, r); check(r == 0, "R8 write 1 clears", r, 0);
        check(!irq, "R9 irq low after clear", {31'd0, irq}, 0);
        repeat (100) @(negedge bus_clk);
        rd(A_STAT, r); check(r == 0, "R8 stays clear", r, 0);
    endtask

    // R9, R10, R7: gating by applied enables; disabled alarm never sets flag
    task automatic t_gating();
        logic [31:0] r;
        set_ctrl(32'h0, "R2 disable applied");
        wr(A_STAT, 32'h1);
        load_raw(32'h0, 32'd20 << FRAC_W, "R6 load 20 s");
        wr(A_ALM, 32'd21);
        set_ctrl(32'h3, "R2 count+alarm applied");
        wait_irq("R9 irq without wake enable");
        check(!wakeup, "R10 wakeup gated", {31'd0, wakeup}, 0);
        set_ctrl(32'h1, "R2 alarm disable applied");
        check(!irq, "R9 irq masked by alarm enable", {31'd0, irq}, 0);
        rd(A_STAT, r); check(r == 1, "R9 flag stays while masked", r, 1);
        wr(A_STAT, 32'h1);
        rd(A_LO, r);
        wr(A_ALM, (r >> FRAC_W) + 2);
        repeat (3000) @(negedge bus_clk);
        rd(A_STAT, r); check(r == 0, "R7 disabled alarm no flag", r, 0);
        check(!irq, "R9 irq low", {31'd0, irq}, 0);
    endtask

    // R11: glitch-detect word storage
    task automatic t_glitch();
        logic [31:0] r;
        wr(A_GLT, 32'h4173_6166);
        rd(A_GLT, r); check(r == 32'h4173_6166, "R11 init value", r, 32'h4173_6166);
        wr(A_GLT, 32'h0F0F_A5A5);
        rd(A_GLT, r); check(r == 32'h0F0F_A5A5, "R11 any value", r, 32'h0F0F_A5A5);
    endtask

    initial begin
        repeat (100) @(negedge bus_clk);
        rst_n = 1'b1;
        repeat (4) @(negedge bus_clk);
        t_reset();
        t_enable();
        t_load();
        t_alarm();
        t_gating();
        t_glitch();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge bus_clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule